// File: doc/BRIEF.md
# Master Clock Ratio and Clock-Stop Detector

This block sits in front of an audio converter's digital datapath. It counts how many master-clock periods fall inside one frame-clock period, names the ratio it finds, and from that ratio picks the oversampling speed: normal, double or quad. When automatic selection is turned off, the datapath always runs at normal speed, and only the ratios that normal speed allows are accepted. The de-emphasis request is passed through only while the block runs at normal speed.

All inputs are sampled in one free-running reference clock domain. That reference clock must run at least twice as fast as the master clock. The detector also watches the three audio clocks for a stop. A master clock with no edge for a set number of reference cycles counts as stopped. So does a frame clock or bit clock with no edge for 2048 master-clock periods. While any clock is stopped, `clocks_ok_o` stays low, and that signal holds the downstream logic in power-down. After a stop, or after reset, nothing is measured until the first frame-clock rising edge. A ratio is then accepted only after two consecutive frames have measured the same ratio.

Top module: `mclk_ratio_detect`

## Requirements
- R1: With `auto_sel_i`=1, a ratio of 512, 768 or 1152 gives `ratio_code_o` 5, 6 or 7 and `speed_o`=0 (normal).
- R2: With `auto_sel_i`=1, a ratio of 256 or 384 gives `ratio_code_o` 3 or 4 and `speed_o`=1 (double).
- R3: With `auto_sel_i`=1, a ratio of 128 or 192 gives `ratio_code_o` 1 or 2 and `speed_o`=2 (quad).
- R4: With `auto_sel_i`=0, `speed_o` is always 0. The ratios 256, 384, 512, 768 and 1152 lock. A ratio of 128 or 192 leaves `clocks_ok_o`=0 and `ratio_code_o`=0. A change of `auto_sel_i` acts on the outputs at once.
- R5: `deemph_en_o` equals `deemph_req_i` when `clocks_ok_o`=1 and `speed_o`=0. It is 0 in every other case, including at double and quad speed.
- R6: A measured count within ±2 of a nominal ratio matches that ratio. A count further away matches nothing. Two such frames in a row drop the lock.
- R7: The first frame-clock rising edge after reset or after a stop only starts counting. A ratio is accepted when two consecutive complete frames measure the same ratio, so lock comes no earlier than the third rising edge.
- R8: A frame clock or bit clock with no edge for 2048 master-clock rising edges drops `clocks_ok_o` to 0 and clears the accepted ratio.
- R9: A master clock with no edge for `MCLK_TIMEOUT` (default 64) reference cycles drops `clocks_ok_o` to 0. A shorter pause of 50 cycles keeps the lock.
- R10: Once all clocks run again after a stop, lock returns only through the sequence of R7.
- R11: During reset, and until lock, all outputs are 0: `ratio_code_o`=0, `speed_o`=0, `deemph_en_o`=0, `clocks_ok_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock, faster than twice the master clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master clock, sampled as data |
| lrck_i | input | 1 | Frame clock, one period per sample frame |
| bclk_i | input | 1 | Serial bit clock, watched for activity only |
| auto_sel_i | input | 1 | 1: speed chosen from ratio, 0: fixed normal speed |
| deemph_req_i | input | 1 | De-emphasis request from control logic |
| ratio_code_o | output | 3 | Locked ratio: 0 none, 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1152 |
| speed_o | output | 2 | 0 normal, 1 double, 2 quad |
| deemph_en_o | output | 1 | De-emphasis permitted and requested |
| clocks_ok_o | output | 1 | All clocks running and a valid ratio locked; low holds power-down |

## Verification
The assertions assume that each of the three audio clocks holds every level for at least one reference cycle. They also assume that the frame clock never rises in the same reference cycle as a master-clock rise. Without that, the count of a frame could shift by one. The stimulus toggles the master clock on every reference cycle. It moves the frame clock and bit clock only on master-clock falling edges, so every frame contains exactly the intended number of master-clock rises. Stops are made by freezing one clock while the others keep running. The master-clock pauses are chosen both below and above the timeout.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5,
    RC_768  = 3'd6,
    RC_1152 = 3'd7
  } ratio_code_e;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  localparam int unsigned MAX_NOMINAL = 1152;

  function automatic int unsigned nominal_ratio(ratio_code_e c);
    case (c)
      RC_128:  return 128;
      RC_192:  return 192;
      RC_256:  return 256;
      RC_384:  return 384;
      RC_512:  return 512;
      RC_768:  return 768;
      RC_1152: return 1152;
      default: return 0;
    endcase
  endfunction

  // Nearest nominal ratio within +/- tol, or RC_NONE.
  function automatic ratio_code_e classify(int unsigned cnt, int unsigned tol);
    ratio_code_e res;
    res = RC_NONE;
    for (int i = 1; i < 8; i++) begin
      if ((cnt + tol >= nominal_ratio(ratio_code_e'(3'(i)))) &&
          (cnt <= nominal_ratio(ratio_code_e'(3'(i))) + tol))
        res = ratio_code_e'(3'(i));
    end
    return res;
  endfunction

  function automatic speed_e speed_of(ratio_code_e c);
    case (c)
      RC_128, RC_192: return SPD_QUAD;
      RC_256, RC_384: return SPD_DOUBLE;
      default:        return SPD_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/stop_watch.sv
module stop_watch #(
  parameter int unsigned LIMIT = 2048
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic dead_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (tick_i && (cnt_q != CW'(LIMIT)))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign dead_o = (cnt_q == CW'(LIMIT));

  // A stop verdict stays until the watched clock moves (also covers R9).
  assert_dead_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dead_o && !clr_i) |=> dead_o);
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
  import mclk_ratio_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int unsigned TOL = 2
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        mclk_rise_i,
  input  logic        lrck_rise_i,
  input  logic        kill_i,
  output ratio_code_e accepted_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             started_q, started_d;
  ratio_code_e      prev_q, prev_d, acc_q, acc_d, meas;

  always_comb begin
    cnt_d     = cnt_q;
    started_d = started_q;
    prev_d    = prev_q;
    acc_d     = acc_q;
    meas      = classify(32'(cnt_q), TOL);
    if (kill_i) begin
      cnt_d     = '0;
      started_d = 1'b0;
      prev_d    = RC_NONE;
      acc_d     = RC_NONE;
    end else if (lrck_rise_i) begin
      started_d = 1'b1;
      cnt_d     = CNT_W'(mclk_rise_i);
      if (started_q) begin
        prev_d = meas;
        if (meas == prev_q) acc_d = meas;
      end
    end else if (mclk_rise_i && (cnt_q != '1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      prev_q    <= RC_NONE;
      acc_q     <= RC_NONE;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
      prev_q    <= prev_d;
      acc_q     <= acc_d;
    end
  end

  assign accepted_o = acc_q;

  // A newly accepted ratio must equal the one measured on the frame before.
  assert_two_frame_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((acc_q != $past(acc_q)) && (acc_q != RC_NONE)) |-> ($past(prev_q) == acc_q));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mclk_ratio_pkg::*;
#(
  parameter int unsigned TOL          = 2,
  parameter int unsigned EDGE_LIMIT   = 2048,
  parameter int unsigned MCLK_TIMEOUT = 64
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       mclk_i,
  input  logic       lrck_i,
  input  logic       bclk_i,
  input  logic       auto_sel_i,
  input  logic       deemph_req_i,
  output logic [2:0] ratio_code_o,
  output logic [1:0] speed_o,
  output logic       deemph_en_o,
  output logic       clocks_ok_o
);
  localparam int CNT_W = $clog2(MAX_NOMINAL + 2 * TOL + 1) + 1;
  localparam int NCLK  = 3;   // 0 master, 1 frame, 2 bit

  logic            rst_q1, rst_q2, rst_n;
  logic [NCLK-1:0] lvl, prev, any_edge;
  logic            mclk_rise, lrck_rise, mclk_dead, any_dead, locked;
  logic [1:0]      aux_dead;
  ratio_code_e     acc;
  speed_e          spd;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_n = rst_q2;

  edge_sync #(.W(NCLK)) sync_i (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .din_i({bclk_i, lrck_i, mclk_i}),
    .lvl_o(lvl), .prev_o(prev)
  );

  assign any_edge  = lvl ^ prev;
  assign mclk_rise = lvl[0] & ~prev[0];
  assign lrck_rise = lvl[1] & ~prev[1];

  stop_watch #(.LIMIT(MCLK_TIMEOUT)) mclk_wd_i (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .tick_i(1'b1), .clr_i(any_edge[0]), .dead_o(mclk_dead)
  );

  for (genvar g = 0; g < 2; g++) begin : g_aux_wd
    stop_watch #(.LIMIT(EDGE_LIMIT)) wd_i (
      .clk_i(clk_i), .rst_n_i(rst_n),
      .tick_i(mclk_rise), .clr_i(any_edge[g+1]), .dead_o(aux_dead[g])
    );
  end

  assign any_dead = mclk_dead | (|aux_dead);

  ratio_meter #(.CNT_W(CNT_W), .TOL(TOL)) meter_i (
    .clk_i(clk_i), .rst_n_i(rst_n),
    .mclk_rise_i(mclk_rise), .lrck_rise_i(lrck_rise),
    .kill_i(any_dead), .accepted_o(acc)
  );

  always_comb begin
    locked = (acc != RC_NONE) && (auto_sel_i || (speed_of(acc) != SPD_QUAD));
    spd    = SPD_NORMAL;
    if (locked && !any_dead && auto_sel_i) spd = speed_of(acc);
  end

  assign clocks_ok_o  = locked & ~any_dead;
  assign ratio_code_o = clocks_ok_o ? acc : RC_NONE;
  assign speed_o      = spd;
  assign deemph_en_o  = clocks_ok_o && (spd == SPD_NORMAL) && deemph_req_i;

  assert_manual_normal_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !auto_sel_i |-> (speed_o == SPD_NORMAL));

  assert_manual_rejects_quad_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!auto_sel_i && ((acc == RC_128) || (acc == RC_192))) |-> !clocks_ok_o);

  assert_fast_no_deemph_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (speed_o != SPD_NORMAL) |-> !deemph_en_o);

  assert_stop_drops_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    any_dead |=> (acc == RC_NONE));
endmodule

// File: tb/mclk_ratio_detect_tb_top.sv
module mclk_ratio_detect_tb_top;

  localparam int TOL = 2;
  localparam int LT  = 2048;
  localparam int MT  = 64;
  localparam int CMAX = 4095;
  localparam int NOM [8] = '{0, 128, 192, 256, 384, 512, 768, 1152};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mclk, lrck, bclk, auto_sel, deemph_req;
  logic [2:0] ratio_code;
  logic [1:0] speed;
  logic deemph_en, clocks_ok;

  mclk_ratio_detect dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .mclk_i(mclk), .lrck_i(lrck), .bclk_i(bclk),
    .auto_sel_i(auto_sel), .deemph_req_i(deemph_req),
    .ratio_code_o(ratio_code), .speed_o(speed),
    .deemph_en_o(deemph_en), .clocks_ok_o(clocks_ok)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R11";
  int pos = 0;

  // ---------------- behavioural model ----------------
  int pm, pl, pb, cnt, started, prevc, acc, mwd, lwd, bwd;
  int d_acc [3];
  int d_dead [3];

  function automatic int m_classify(int c);
    int r = 0;
    for (int i = 1; i < 8; i++)
      if (c >= NOM[i] - TOL && c <= NOM[i] + TOL) r = i;
    return r;
  endfunction

  function automatic int m_speed(int c);
    if (c == 1 || c == 2) return 2;
    if (c == 3 || c == 4) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pm = 0; pl = 0; pb = 0; cnt = 0; started = 0; prevc = 0; acc = 0;
      mwd = 0; lwd = 0; bwd = 0;
      for (int i = 0; i < 3; i++) begin d_acc[i] = 0; d_dead[i] = 0; end
    end else begin
      int mr, me, lr, le, be, dead, c;
      mr = (mclk && !pm); me = (mclk != pm);
      lr = (lrck && !pl); le = (lrck != pl); be = (bclk != pb);
      dead = (mwd == MT) || (lwd == LT) || (bwd == LT);
      if (dead) begin
        cnt = 0; started = 0; prevc = 0; acc = 0;
      end else if (lr) begin
        c = m_classify(cnt);
        if (started) begin
          if (c == prevc) acc = c;
          prevc = c;
        end
        started = 1;
        cnt = mr ? 1 : 0;
      end else if (mr && cnt < CMAX) cnt++;
      if (me) mwd = 0; else if (mwd < MT) mwd++;
      if (le) lwd = 0; else if (mr && lwd < LT) lwd++;
      if (be) bwd = 0; else if (mr && bwd < LT) bwd++;
      pm = mclk; pl = lrck; pb = bclk;
      d_acc[2] = d_acc[1]; d_dead[2] = d_dead[1];
      d_acc[1] = d_acc[0]; d_dead[1] = d_dead[0];
      d_acc[0] = acc;
      d_dead[0] = (mwd == MT) || (lwd == LT) || (bwd == LT);
    end
  end

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int eo, ec, es, ed;
      eo = (d_acc[2] != 0) && (auto_sel || m_speed(d_acc[2]) != 2) && !d_dead[2];
      ec = eo ? d_acc[2] : 0;
      es = (eo && auto_sel) ? m_speed(d_acc[2]) : 0;
      ed = eo && es == 0 && deemph_req;
      checks++;
      if (clocks_ok !== 1'(eo) || ratio_code !== 3'(ec) || speed !== 2'(es) || deemph_en !== 1'(ed)) begin
        fails++;
        $display("FAIL %s model: got ok=%0b code=%0d spd=%0d de=%0b expected ok=%0d code=%0d spd=%0d de=%0d",
                 cur_req, clocks_ok, ratio_code, speed, deemph_en, eo, ec, es, ed);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic run(int ratio, int periods, bit lrun, bit brun);
    pos = pos % ratio;
    for (int k = 0; k < periods * 2; k++) begin
      @(posedge clk); #2;
      if (mclk) begin
        mclk = 1'b0;
        if (brun) bclk = ~bclk;
        if (lrun) lrck = (pos < ratio / 2);
      end else begin
        mclk = 1'b1;
        pos = (pos + 1) % ratio;
      end
    end
  endtask

  task automatic expect_out(string req, bit ok, int code, int spd, bit de);
    @(negedge clk);
    checks++;
    if (clocks_ok !== ok || ratio_code !== 3'(code) || speed !== 2'(spd) || deemph_en !== de) begin
      fails++;
      $display("FAIL %s: got ok=%0b code=%0d spd=%0d de=%0b expected ok=%0b code=%0d spd=%0d de=%0b",
               req, clocks_ok, ratio_code, speed, deemph_en, ok, code, spd, de);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all R): got hung run expected completion");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mclk = 1'b0; lrck = 1'b0; bclk = 1'b0;
    auto_sel = 1'b1; deemph_req = 1'b1;
    repeat (4) @(posedge clk);
    expect_out("R11", 0, 0, 0, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    idle(10);
    expect_out("R11", 0, 0, 0, 0);

    cur_req = "R7";
    run(512, 1000, 1, 1);              // two rising edges only
    expect_out("R7", 0, 0, 0, 0);
    run(512, 100, 1, 1);               // third rising edge accepts
    expect_out("R7", 1, 5, 0, 1);

    cur_req = "R1";
    run(768, 5 * 768, 1, 1);  expect_out("R1", 1, 6, 0, 1);
    run(1152, 5 * 1152, 1, 1); expect_out("R1", 1, 7, 0, 1);

    cur_req = "R2";
    run(256, 5 * 256, 1, 1);  expect_out("R2", 1, 3, 1, 0);
    run(384, 5 * 384, 1, 1);  expect_out("R5", 1, 4, 1, 0);

    cur_req = "R3";
    run(128, 5 * 128, 1, 1);  expect_out("R3", 1, 1, 2, 0);
    run(192, 5 * 192, 1, 1);  expect_out("R3", 1, 2, 2, 0);

    cur_req = "R6";
    run(514, 5 * 514, 1, 1);   expect_out("R6", 1, 5, 0, 1);
    run(510, 5 * 510, 1, 1);   expect_out("R6", 1, 5, 0, 1);
    run(515, 5 * 515, 1, 1);   expect_out("R6", 0, 0, 0, 0);
    run(1150, 5 * 1150, 1, 1); expect_out("R6", 1, 7, 0, 1);

    cur_req = "R4";
    auto_sel = 1'b0;
    run(256, 5 * 256, 1, 1);  expect_out("R4", 1, 3, 0, 1);
    @(posedge clk); #2; auto_sel = 1'b1;
    expect_out("R4", 1, 3, 1, 0);
    @(posedge clk); #2; auto_sel = 1'b0;
    run(128, 5 * 128, 1, 1);  expect_out("R4", 0, 0, 0, 0);
    run(1152, 5 * 1152, 1, 1); expect_out("R4", 1, 7, 0, 1);
    cur_req = "R5";
    @(posedge clk); #2; deemph_req = 1'b0;
    expect_out("R5", 1, 7, 0, 0);
    @(posedge clk); #2; deemph_req = 1'b1; auto_sel = 1'b1;

    cur_req = "R8";
    run(512, 5 * 512, 1, 1);  expect_out("R8", 1, 5, 0, 1);
    run(512, 2100, 0, 1);     expect_out("R8", 0, 0, 0, 0);
    cur_req = "R10";
    run(512, 300, 1, 1);      expect_out("R10", 0, 0, 0, 0);
    run(512, 5 * 512, 1, 1);  expect_out("R10", 1, 5, 0, 1);

    cur_req = "R8";
    run(512, 2100, 1, 0);     expect_out("R8", 0, 0, 0, 0);
    run(512, 5 * 512, 1, 1);  expect_out("R10", 1, 5, 0, 1);

    cur_req = "R9";
    idle(50);                 expect_out("R9", 1, 5, 0, 1);
    idle(100);                expect_out("R9", 0, 0, 0, 0);
    cur_req = "R10";
    run(512, 5 * 512, 1, 1);  expect_out("R10", 1, 5, 0, 1);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule